// File: doc/BRIEF.md
# UART Register-Access Command Slave

This block sits behind a byte-wide UART receiver and transmitter. It gives a host read and write access to a byte-addressed register space. The host sends framed commands. Each frame is a four-byte header, an optional payload and a CRC-16. The block checks the frame. It then either writes the payload into consecutive registers or returns register contents followed by a CRC. Every command is answered with a one-byte acknowledge or negative-acknowledge code. Each command type has its own pair of codes.

Addresses 0 to 7 are served by a small internal identity bank:

| Address | Content | Access |
|---|---|---|
| 0 | identity byte 0x59 | read-only |
| 1 | revision byte (parameter) | read-only |
| 2 | diagnostic byte | read/write |
| 3 | pad byte 0 | read-only |
| 4, 5 | status word from a pin | read-only |
| 6, 7 | control word driving a pin | read/write |

Addresses from 8 up to the end of the map go to an external register-file port. That port has a combinational read and a single-cycle write strobe. A write payload is buffered completely and is committed only after its CRC has been checked. A rejected frame therefore never touches a register.

Top module: `uart_reg_slave`

## Requirements
- R1: A read frame is 0x5A, address low byte, address high byte, count, then a CRC over those 4 bytes. The CRC is CRC-16/CCITT (polynomial 0x1021, initial value 0xFFFF, no reflection) and is sent low byte first. A valid read frame is answered with 0xAA, then count bytes from consecutive addresses, then a CRC over 0xAA and the data, low byte first.
- R2: A write frame is 0x55, address low byte, address high byte, count, count payload bytes, then a CRC over header and payload, low byte first. A valid write frame stores the payload at consecutive addresses. Only after that is it answered with the single byte 0xA5.
- R3: The identity bank holds:
  - 0x59 at address 0 and the REV parameter at address 1;
  - a writable diagnostic byte at address 2 (reset 0) and 0 at address 3;
  - status_i at addresses 4 (low byte) and 5 (high byte);
  - a writable control word at addresses 6 (low byte) and 7 (high byte), reset 0, which drives ctrl_o.

  Writes to addresses 0, 1, 3, 4 and 5 have no effect.
- R4: A frame whose received CRC does not match is rejected. A write is answered 0xAE and a read 0xAF, and no register changes.
- R5: A frame with count 0, or with address plus count greater than MAP_SIZE, is rejected with 0xAE (write) or 0xAF (read). No register changes. The last address MAP_SIZE-1 is reachable.
- R6: A first byte that is neither 0x55 nor 0x5A is answered with the single byte 0xAE. The next byte is again taken as an opcode.
- R7: When TIMEOUT cycles pass without a received byte inside a partial frame, the frame is dropped without a reply. The next byte is taken as an opcode.
- R8: The transmit byte is held stable while tx_valid_o is high and tx_ready_i is low. Every reply byte is sent exactly once, in order, under any pattern of back-pressure.
- R9: reg_we_o is raised only for addresses 8 to MAP_SIZE-1. Those writes happen while no reply byte is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| rx_data_i | input | 8 | received byte |
| rx_valid_i | input | 1 | received byte valid, one cycle per byte |
| tx_data_o | output | 8 | byte to transmit |
| tx_valid_o | output | 1 | transmit byte valid |
| tx_ready_i | input | 1 | transmitter accepts the byte |
| reg_addr_o | output | 16 | register-file address |
| reg_wdata_o | output | 8 | register-file write data |
| reg_we_o | output | 1 | register-file write strobe |
| reg_rdata_i | input | 8 | register-file read data for reg_addr_o, combinational |
| status_i | input | 16 | status word shown at addresses 4 and 5 |
| ctrl_o | output | 16 | control word held at addresses 6 and 7 |

## Verification
The bench builds the block with the following parameters:
- MAP_SIZE of 40, so that a range that runs past the map, and one that ends exactly on its last byte, are cheap to reach with short frames.
- TIMEOUT of 50 cycles, so that a stalled partial frame expires within a short wait and the frame that follows can prove that the parser resynchronised.
- REV of 0x03, so that the revision byte differs from every other value read from the identity bank.

// File: rtl/uart_reg_slave_pkg.sv
package uart_reg_slave_pkg;
  localparam logic [7:0] OP_WR  = 8'h55;
  localparam logic [7:0] OP_RD  = 8'h5A;
  localparam logic [7:0] ACK_WR = 8'hA5;
  localparam logic [7:0] NAK_WR = 8'hAE;
  localparam logic [7:0] ACK_RD = 8'hAA;
  localparam logic [7:0] NAK_RD = 8'hAF;
  localparam logic [7:0] ID_VAL = 8'h59;
  localparam int unsigned HDR_BYTES = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_PAY, S_CRCL, S_CRCH, S_EXEC,
    S_RDAT, S_RCRCL, S_RCRCH, S_TXL
  } state_e;

  function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] b);
    logic [15:0] x;
    x = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
    return x;
  endfunction
endpackage

// File: rtl/urs_crc16.sv
module urs_crc16 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        upd_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  import uart_reg_slave_pkg::*;
  logic [15:0] crc_q, base;

  // init and update together start a fresh CRC from this byte
  assign base = init_i ? 16'hFFFF : crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= 16'hFFFF;
    else if (upd_i)  crc_q <= crc_step(base, byte_i);
    else if (init_i) crc_q <= 16'hFFFF;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/urs_hdr_bank.sv
module urs_hdr_bank #(
  parameter logic [7:0] REV = 8'h01
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [2:0]  waddr_i,
  input  logic [7:0]  wdata_i,
  input  logic [2:0]  raddr_i,
  output logic [7:0]  rdata_o,
  input  logic [15:0] status_i,
  output logic [15:0] ctrl_o
);
  import uart_reg_slave_pkg::*;
  logic [7:0]  diag_q;
  logic [15:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diag_q <= '0;
      ctrl_q <= '0;
    end else if (we_i) begin
      case (waddr_i)
        3'd2: diag_q        <= wdata_i;
        3'd6: ctrl_q[7:0]   <= wdata_i;
        3'd7: ctrl_q[15:8]  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (raddr_i)
      3'd0:    rdata_o = ID_VAL;
      3'd1:    rdata_o = REV;
      3'd2:    rdata_o = diag_q;
      3'd4:    rdata_o = status_i[7:0];
      3'd5:    rdata_o = status_i[15:8];
      3'd6:    rdata_o = ctrl_q[7:0];
      3'd7:    rdata_o = ctrl_q[15:8];
      default: rdata_o = 8'h00;
    endcase
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/urs_pay_buf.sv
module urs_pay_buf #(
  parameter int unsigned DEPTH = 256
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [7:0]               wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [7:0]               rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) if (we_i) mem[waddr_i] <= wdata_i;

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/uart_reg_slave.sv
module uart_reg_slave #(
  parameter int unsigned MAP_SIZE = 264,
  parameter int unsigned TIMEOUT  = 1000,
  parameter logic [7:0]  REV      = 8'h01
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_valid_i,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  output logic [15:0] reg_addr_o,
  output logic [7:0]  reg_wdata_o,
  output logic        reg_we_o,
  input  logic [7:0]  reg_rdata_i,
  input  logic [15:0] status_i,
  output logic [15:0] ctrl_o
);
  import uart_reg_slave_pkg::*;

  localparam int unsigned TW = $clog2(TIMEOUT + 1);
  localparam logic [16:0] MAP_END = 17'(MAP_SIZE);

  state_e      state_q;
  logic        is_wr_q;
  logic [15:0] addr_q;
  logic [7:0]  cnt_q, idx_q, crc_lo_q;
  logic [TW-1:0] tmo_q;
  logic [7:0]  tx_data_q;
  logic        tx_valid_q;

  logic        crc_init, crc_upd;
  logic [7:0]  crc_byte;
  logic [15:0] crc_val;
  logic [15:0] acc_addr;
  logic        in_hdr, range_ok, frame_ok, tx_free, op_known, exec_active;
  logic [7:0]  hdr_rdata, buf_rdata, rd_byte;

  assign acc_addr    = addr_q + {8'h00, idx_q};
  assign in_hdr      = (acc_addr[15:3] == '0);
  assign range_ok    = (({1'b0, addr_q} + {9'h000, cnt_q}) <= MAP_END) && (cnt_q != 8'h00);
  assign frame_ok    = ({rx_data_i, crc_lo_q} == crc_val) && range_ok;
  assign tx_free     = !tx_valid_q || tx_ready_i;
  assign op_known    = (rx_data_i == OP_WR) || (rx_data_i == OP_RD);
  assign exec_active = (state_q == S_EXEC);
  assign rd_byte     = in_hdr ? hdr_rdata : reg_rdata_i;

  urs_crc16 u_crc (
    .clk_i, .rst_ni, .init_i(crc_init), .upd_i(crc_upd), .byte_i(crc_byte), .crc_o(crc_val)
  );

  urs_hdr_bank #(.REV(REV)) u_hdr (
    .clk_i, .rst_ni,
    .we_i(exec_active && in_hdr), .waddr_i(acc_addr[2:0]), .wdata_i(buf_rdata),
    .raddr_i(acc_addr[2:0]), .rdata_o(hdr_rdata),
    .status_i, .ctrl_o
  );

  urs_pay_buf #(.DEPTH(256)) u_buf (
    .clk_i,
    .we_i(state_q == S_PAY && rx_valid_i), .waddr_i(idx_q), .wdata_i(rx_data_i),
    .raddr_i(idx_q), .rdata_o(buf_rdata)
  );

  always_comb begin
    crc_init = 1'b0;
    crc_upd  = 1'b0;
    crc_byte = rx_data_i;
    case (state_q)
      S_IDLE: if (rx_valid_i && op_known) begin crc_init = 1'b1; crc_upd = 1'b1; end
      S_HDR, S_PAY: crc_upd = rx_valid_i;
      S_CRCH: if (rx_valid_i && frame_ok && !is_wr_q) begin
        crc_init = 1'b1; crc_upd = 1'b1; crc_byte = ACK_RD;
      end
      S_RDAT: if (tx_free) begin crc_upd = 1'b1; crc_byte = rd_byte; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      is_wr_q    <= 1'b0;
      addr_q     <= '0;
      cnt_q      <= '0;
      idx_q      <= '0;
      crc_lo_q   <= '0;
      tmo_q      <= '0;
      tx_data_q  <= '0;
      tx_valid_q <= 1'b0;
    end else begin
      if (tx_valid_q && tx_ready_i) tx_valid_q <= 1'b0;
      if (state_q inside {S_HDR, S_PAY, S_CRCL, S_CRCH}) begin
        if (rx_valid_i) tmo_q <= '0;
        else if (tmo_q == TW'(TIMEOUT - 1)) begin
          tmo_q   <= '0;
          state_q <= S_IDLE;
        end else tmo_q <= tmo_q + 1'b1;
      end
      case (state_q)
        S_IDLE: if (rx_valid_i) begin
          tmo_q <= '0;
          if (op_known) begin
            is_wr_q <= (rx_data_i == OP_WR);
            idx_q   <= 8'd1;
            state_q <= S_HDR;
          end else begin
            tx_data_q  <= NAK_WR;
            tx_valid_q <= 1'b1;
            state_q    <= S_TXL;
          end
        end
        S_HDR: if (rx_valid_i) begin
          idx_q <= idx_q + 1'b1;
          case (idx_q[1:0])
            2'd1: addr_q[7:0]  <= rx_data_i;
            2'd2: addr_q[15:8] <= rx_data_i;
            default: begin
              cnt_q   <= rx_data_i;
              idx_q   <= '0;
              state_q <= (is_wr_q && rx_data_i != 8'h00) ? S_PAY : S_CRCL;
            end
          endcase
        end
        S_PAY: if (rx_valid_i) begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == cnt_q - 1'b1) state_q <= S_CRCL;
        end
        S_CRCL: if (rx_valid_i) begin
          crc_lo_q <= rx_data_i;
          state_q  <= S_CRCH;
        end
        S_CRCH: if (rx_valid_i) begin
          idx_q <= '0;
          if (frame_ok) begin
            if (is_wr_q) state_q <= S_EXEC;
            else begin
              tx_data_q  <= ACK_RD;
              tx_valid_q <= 1'b1;
              state_q    <= S_RDAT;
            end
          end else begin
            tx_data_q  <= is_wr_q ? NAK_WR : NAK_RD;
            tx_valid_q <= 1'b1;
            state_q    <= S_TXL;
          end
        end
        S_EXEC: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == cnt_q - 1'b1) begin
            tx_data_q  <= ACK_WR;
            tx_valid_q <= 1'b1;
            state_q    <= S_TXL;
          end
        end
        S_RDAT: if (tx_free) begin
          tx_data_q  <= rd_byte;
          tx_valid_q <= 1'b1;
          idx_q      <= idx_q + 1'b1;
          if (idx_q == cnt_q - 1'b1) state_q <= S_RCRCL;
        end
        S_RCRCL: if (tx_free) begin
          tx_data_q  <= crc_val[7:0];
          tx_valid_q <= 1'b1;
          state_q    <= S_RCRCH;
        end
        S_RCRCH: if (tx_free) begin
          tx_data_q  <= crc_val[15:8];
          tx_valid_q <= 1'b1;
          state_q    <= S_TXL;
        end
        S_TXL: if (tx_valid_q && tx_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign tx_data_o   = tx_data_q;
  assign tx_valid_o  = tx_valid_q;
  assign reg_addr_o  = acc_addr;
  assign reg_wdata_o = buf_rdata;
  assign reg_we_o    = exec_active && !in_hdr;
endmodule

// File: rtl/urs_checker.sv
module urs_checker #(
  parameter int unsigned MAP_SIZE = 264
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  tx_data_i,
  input logic        tx_valid_i,
  input logic        tx_ready_i,
  input logic [15:0] reg_addr_i,
  input logic        reg_we_i,
  input logic [15:0] ctrl_i,
  input logic        exec_i
);
  p_tx_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && !tx_ready_i) |=> (tx_valid_i && $stable(tx_data_i)));

  p_we_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |-> (reg_addr_i >= 16'd8 && 32'(reg_addr_i) < MAP_SIZE));

  p_we_no_reply_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |-> !tx_valid_i);

  p_ctrl_by_exec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_i) |-> $past(exec_i));
endmodule

bind uart_reg_slave urs_checker #(.MAP_SIZE(MAP_SIZE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_data_i(tx_data_o), .tx_valid_i(tx_valid_o),
  .tx_ready_i(tx_ready_i), .reg_addr_i(reg_addr_o), .reg_we_i(reg_we_o),
  .ctrl_i(ctrl_o), .exec_i(exec_active)
);

// File: tb/uart_reg_slave_tb.sv
module uart_reg_slave_tb;
  localparam int unsigned MAP = 40;
  localparam int unsigned TMO = 50;
  localparam logic [7:0]  REVV = 8'h03;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0, tx_ready = 1'b1;
  logic [7:0] tx_data, reg_wdata;
  logic tx_valid, reg_we;
  logic [15:0] reg_addr, ctrl;
  logic [7:0] reg_rdata;
  logic [15:0] status = 16'hBEEF;

  always #10 clk = ~clk;

  uart_reg_slave #(.MAP_SIZE(MAP), .TIMEOUT(TMO), .REV(REVV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_we_o(reg_we),
    .reg_rdata_i(reg_rdata), .status_i(status), .ctrl_o(ctrl)
  );

  logic [7:0] ext_mem [64];
  logic [7:0] shadow  [64];
  assign reg_rdata = ext_mem[reg_addr[5:0]];
  always @(posedge clk) if (reg_we) ext_mem[reg_addr[5:0]] <= reg_wdata;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [7:0] rxq[$];
  logic [7:0] pay_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] diag_e = 8'h00;
  logic [15:0] ctrl_e = 16'h0000;

  always @(negedge clk) if (tx_valid && tx_ready) rxq.push_back(tx_data);

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: act=%0d cycles exp=finish", cyc);
      summary();
    end
  end

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] crc_b(logic [15:0] c, logic [7:0] b);
    logic [15:0] x;
    x = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
    return x;
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    case (a)
      0: return 8'h59;
      1: return REVV;
      2: return diag_e;
      3: return 8'h00;
      4: return status[7:0];
      5: return status[15:8];
      6: return ctrl_e[7:0];
      7: return ctrl_e[15:8];
      default: return shadow[a];
    endcase
  endfunction

  task automatic put(logic [7:0] b);
    @(negedge clk);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // frame from header and pay_q; bad flips the CRC low byte
  task automatic send_cmd(logic [7:0] op, logic [15:0] addr, logic [7:0] cnt, bit bad);
    logic [15:0] c;
    c = 16'hFFFF;
    c = crc_b(c, op); c = crc_b(c, addr[7:0]); c = crc_b(c, addr[15:8]); c = crc_b(c, cnt);
    foreach (pay_q[i]) c = crc_b(c, pay_q[i]);
    if (bad) c = c ^ 16'h0001;
    put(op); put(addr[7:0]); put(addr[15:8]); put(cnt);
    foreach (pay_q[i]) put(pay_q[i]);
    put(c[7:0]); put(c[15:8]);
  endtask

  task automatic expect_reply(string tag);
    int w;
    w = 0;
    while (rxq.size() < exp_q.size() && w < 3000) begin @(negedge clk); w++; end
    repeat (30) @(negedge clk);
    chk(rxq.size() == exp_q.size(), {tag, " length"}, rxq.size(), exp_q.size());
    foreach (exp_q[i])
      if (i < rxq.size()) chk(rxq[i] == exp_q[i], {tag, " byte"}, rxq[i], exp_q[i]);
    rxq.delete();
    exp_q.delete();
  endtask

  task automatic build_read_exp(int a, int n);
    logic [15:0] c;
    c = crc_b(16'hFFFF, 8'hAA);
    exp_q.push_back(8'hAA);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(exp_rd(a + i));
      c = crc_b(c, exp_rd(a + i));
    end
    exp_q.push_back(c[7:0]);
    exp_q.push_back(c[15:8]);
  endtask

  task automatic t_reset();
    chk(tx_valid == 1'b0, "R8 reset tx_valid", tx_valid, 0);
    chk(reg_we == 1'b0, "R9 reset reg_we", reg_we, 0);
    chk(ctrl == 16'h0000, "R3 reset ctrl", ctrl, 0);
  endtask

  task automatic t_read_ident();
    pay_q.delete();
    send_cmd(8'h5A, 16'd0, 8'd8, 0);
    build_read_exp(0, 8);
    expect_reply("R1 R3 identity read");
  endtask

  task automatic t_write_ext();
    pay_q.delete();
    for (int i = 0; i < 5; i++) pay_q.push_back(8'h10 + 8'(i * 7));
    send_cmd(8'h55, 16'd8, 8'd5, 0);
    foreach (pay_q[i]) shadow[8 + i] = pay_q[i];
    exp_q.push_back(8'hA5);
    expect_reply("R2 write ack");
    for (int i = 0; i < 5; i++)
      chk(ext_mem[8 + i] == shadow[8 + i], "R2 register content", ext_mem[8 + i], shadow[8 + i]);
    pay_q.delete();
    send_cmd(8'h5A, 16'd8, 8'd5, 0);
    build_read_exp(8, 5);
    expect_reply("R1 R2 read back");
  endtask

  task automatic t_write_hdr();
    pay_q.delete();
    for (int i = 0; i < 8; i++) pay_q.push_back(8'hE0 + 8'(i));
    send_cmd(8'h55, 16'd0, 8'd8, 0);
    diag_e = 8'hE2;
    ctrl_e = 16'hE7E6;
    exp_q.push_back(8'hA5);
    expect_reply("R3 header write ack");
    chk(ctrl == ctrl_e, "R3 ctrl_o", ctrl, ctrl_e);
    pay_q.delete();
    send_cmd(8'h5A, 16'd0, 8'd8, 0);
    build_read_exp(0, 8);
    expect_reply("R3 read-only bytes kept");
  endtask

  task automatic t_bad_crc();
    pay_q.delete();
    pay_q.push_back(8'h99); pay_q.push_back(8'h98);
    send_cmd(8'h55, 16'd8, 8'd2, 1);
    exp_q.push_back(8'hAE);
    expect_reply("R4 bad crc write");
    chk(ext_mem[8] == shadow[8] && ext_mem[9] == shadow[9], "R4 no change",
        {ext_mem[8], ext_mem[9]}, {shadow[8], shadow[9]});
    pay_q.delete();
    send_cmd(8'h5A, 16'd8, 8'd2, 1);
    exp_q.push_back(8'hAF);
    expect_reply("R4 bad crc read");
  endtask

  task automatic t_range();
    pay_q.delete();
    send_cmd(8'h5A, 16'(MAP - 2), 8'd4, 0);
    exp_q.push_back(8'hAF);
    expect_reply("R5 read past end");
    send_cmd(8'h5A, 16'd8, 8'd0, 0);
    exp_q.push_back(8'hAF);
    expect_reply("R5 read count zero");
    send_cmd(8'h55, 16'd8, 8'd0, 0);
    exp_q.push_back(8'hAE);
    expect_reply("R5 write count zero");
    pay_q.push_back(8'h5C); pay_q.push_back(8'h5D);
    send_cmd(8'h55, 16'(MAP - 1), 8'd2, 0);
    exp_q.push_back(8'hAE);
    expect_reply("R5 write past end");
    chk(ext_mem[MAP - 1] == shadow[MAP - 1], "R5 no change at end", ext_mem[MAP - 1], shadow[MAP - 1]);
    pay_q.delete();
    pay_q.push_back(8'h77);
    send_cmd(8'h55, 16'(MAP - 1), 8'd1, 0);
    shadow[MAP - 1] = 8'h77;
    exp_q.push_back(8'hA5);
    expect_reply("R5 write last byte");
    pay_q.delete();
    send_cmd(8'h5A, 16'(MAP - 1), 8'd1, 0);
    build_read_exp(MAP - 1, 1);
    expect_reply("R5 read last byte");
  endtask

  task automatic t_bad_op();
    put(8'h33);
    exp_q.push_back(8'hAE);
    expect_reply("R6 unknown opcode");
    pay_q.delete();
    send_cmd(8'h5A, 16'd1, 8'd1, 0);
    build_read_exp(1, 1);
    expect_reply("R6 resync after opcode");
  endtask

  task automatic t_timeout();
    put(8'h5A); put(8'h00);
    repeat (TMO + 10) @(negedge clk);
    chk(rxq.size() == 0, "R7 no reply on timeout", rxq.size(), 0);
    pay_q.delete();
    send_cmd(8'h5A, 16'd8, 8'd3, 0);
    build_read_exp(8, 3);
    expect_reply("R7 frame after timeout");
  endtask

  task automatic t_backpressure();
    pay_q.delete();
    fork
      begin
        for (int i = 0; i < 400; i++) begin
          @(negedge clk);
          tx_ready = ((i % 3) == 0);
        end
        tx_ready = 1'b1;
      end
      begin
        send_cmd(8'h5A, 16'd4, 8'd10, 0);
        build_read_exp(4, 10);
      end
    join
    expect_reply("R8 read under back-pressure");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      ext_mem[i] = 8'(i) ^ 8'hC3;
      shadow[i]  = 8'(i) ^ 8'hC3;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_read_ident();
    t_write_ext();
    t_write_hdr();
    t_bad_crc();
    t_range();
    t_bad_op();
    t_timeout();
    t_backpressure();
    summary();
  end
endmodule